// File: doc/BRIEF.md
# Atomic compare-and-add instruction sequencer

This block is the control and datapath slice that runs one indivisible memory instruction in a multi-cycle processor. The instruction names four registers. It loads the word at the address held in the first source register. It also loads a full-width constant from the memory word right after the instruction. It compares the two. When they match, it loads a second word through another register, adds the constant to it, and stores the sum at the address held in a third register. In both cases it then writes the truth value of the comparison to the destination register.

The register file has only two read ports. The second port first serves the second source register. It is then switched, at the compare step, to the third address register. A lock output stays high from the first data load until the destination write, so no other master can slip an access in between. At the end the PC moves past both the instruction word and the constant word.

Top module: `atomic_cmpadd_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `mem_req`, `mem_we`, `mem_lock` and `rf_we` are 0 and `pc_out` is 0.
- R2: Register indices come from fixed instruction fields: first source at bits 25:21, second source at 20:16, destination at 15:11, and third address register at 10:6. All other bits are ignored.
- R3: Memory accesses occur in this order, each one cycle long with read data returned the following cycle. First a read at the first source register's value, then a read at `pc_in + 4`. On a match, a read at the second source register's value follows, then a write at the third address register's value.
- R4: On a match, the stored word is the word read through the second source register plus the constant, modulo 2^32.
- R5: On a mismatch, no further memory access follows the constant read, and memory is left unchanged.
- R6: Each instruction ends with exactly one register write to the destination index. The value is 1 on a match and 0 otherwise, with all upper bits zero.
- R7: Every memory access is made with `mem_lock` high. The lock stays high from the first data read through the register-write cycle and is low in the cycle after it.
- R8: After `done`, `pc_out` equals the `pc_in` given at start plus 8.
- R9: `done` is high in the 8th cycle after the cycle in which `start` is taken on a match, and in the 5th cycle on a mismatch.
- R10: `start`, `instr` and `pc_in` are ignored while `busy` is high.
- R11: Read port A always addresses the first source register. Port B addresses the second source register until the compare cycle. In the compare cycle it addresses the third address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing `instr` when idle |
| instr | input | 32 | Instruction word |
| pc_in | input | 32 | Byte address of the instruction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final (register write) cycle |
| pc_out | output | 32 | Program counter, advanced at completion |
| rf_raddr_a | output | 5 | Register read port A index |
| rf_raddr_b | output | 5 | Register read port B index |
| rf_rdata_a | input | 32 | Port A data, combinational |
| rf_rdata_b | input | 32 | Port B data, combinational |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read |
| mem_lock | output | 1 | Bus lock for the whole sequence |

## Verification
The bench builds the block with its default parameters: 32-bit words and the field positions listed above. These defaults bring the modulo-2^32 wrap of the sum within reach, using an all-ones constant. They also allow the index-aliasing cases to be tried, where the third address register equals the second source register, and the register-file reuse shows up at the store address. Runs cover a match, a mismatch, a wrapping match, an aliased store, and a start pulse issued mid-sequence.

// File: rtl/cmpadd_pkg.sv
// Shared types for the atomic compare-and-add sequencer.
// Assumes one instruction in flight at a time.
package cmpadd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RDREG, ST_RDX, ST_RDK, ST_CMP,
        ST_RDY, ST_ADD, ST_STORE, ST_WB
    } state_e;

    typedef enum logic [1:0] {
        ADR_SRC1, ADR_CONST, ADR_SRC2, ADR_DEST
    } adr_sel_e;

    typedef enum logic {
        ALU_CMP, ALU_ADD
    } alu_op_e;

    typedef struct packed {
        logic     mem_req;
        logic     mem_we;
        adr_sel_e adr;
        logic     pair_hi;
        logic     ld_ir;
        logic     ld_ab;
        logic     ld_x;
        logic     ld_cmp;
        logic     ld_sum;
        alu_op_e  op;
        logic     rf_we;
        logic     pc_adv;
        logic     lock;
        logic     busy;
        logic     done;
    } ctl_t;

endpackage

// File: rtl/cmpadd_regsel.sv
// Register index selection: picks the register fields out of the held
// instruction word. Port B is steered to the second source field or to
// the third address field by pair_hi.
// Assumes the field positions are fixed per build.
module cmpadd_regsel #(
    parameter int IW     = 32,
    parameter int RIW    = 5,
    parameter int RS_LSB = 21,
    parameter int RT_LSB = 16,
    parameter int RD_LSB = 11,
    parameter int RU_LSB = 6
) (
    input  logic [IW-1:0]  instr_i,
    input  logic           pair_hi_i,
    output logic [RIW-1:0] raddr_a_o,
    output logic [RIW-1:0] raddr_b_o,
    output logic [RIW-1:0] waddr_o
);
    logic [RIW-1:0] f_src1, f_src2, f_dst, f_adr3;
    logic           unused_ir;

    assign unused_ir = ^instr_i;

    // Field extraction.
    always_comb begin
        f_src1 = instr_i[RS_LSB +: RIW];
        f_src2 = instr_i[RT_LSB +: RIW];
        f_dst  = instr_i[RD_LSB +: RIW];
        f_adr3 = instr_i[RU_LSB +: RIW];
    end

    // Port steering: A fixed on the first source, B switched by pair select.
    always_comb begin
        raddr_a_o = f_src1;
        raddr_b_o = pair_hi_i ? f_adr3 : f_src2;
        waddr_o   = f_dst;
    end
endmodule

// File: rtl/cmpadd_alu.sv
// Two-function ALU: equality compare (result 1 on match) and add.
// Zero flag is high when the result is all zeros, so after a compare
// zero = 1 means the operands differ.
module cmpadd_alu
    import cmpadd_pkg::*;
#(
    parameter int DW = 32
) (
    input  alu_op_e       op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o,
    output logic          zero_o
);
    // Result selection by operation.
    always_comb begin
        unique case (op_i)
            ALU_CMP: res_o = {{(DW-1){1'b0}}, (a_i == b_i)};
            ALU_ADD: res_o = a_i + b_i;
            default: res_o = '0;
        endcase
    end

    // Zero flag.
    assign zero_o = (res_o == '0);
endmodule

// File: rtl/cmpadd_ctrl.sv
// Hard-wired state sequencer for the compare-and-add instruction.
// One state per memory access; branches on the ALU zero flag after the
// compare. Assumes memory read data arrives one cycle after the request.
module cmpadd_ctrl
    import cmpadd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_i,
    output ctl_t ctl_o
);
    state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_RDREG;
            ST_RDREG: state_d = ST_RDX;
            ST_RDX:   state_d = ST_RDK;
            ST_RDK:   state_d = ST_CMP;
            ST_CMP:   state_d = zero_i ? ST_WB : ST_RDY;
            ST_RDY:   state_d = ST_ADD;
            ST_ADD:   state_d = ST_STORE;
            ST_STORE: state_d = ST_WB;
            ST_WB:    state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Control word decode per state.
    always_comb begin
        ctl_o      = '0;
        ctl_o.adr  = ADR_SRC1;
        ctl_o.op   = ALU_CMP;
        ctl_o.lock = !(state_q inside {ST_IDLE, ST_RDREG});
        ctl_o.busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:  ctl_o.ld_ir = start_i;
            ST_RDREG: ctl_o.ld_ab = 1'b1;
            ST_RDX:   ctl_o.mem_req = 1'b1;
            ST_RDK: begin
                ctl_o.mem_req = 1'b1;
                ctl_o.adr     = ADR_CONST;
                ctl_o.ld_x    = 1'b1;
            end
            ST_CMP: begin
                ctl_o.ld_cmp  = 1'b1;
                ctl_o.pair_hi = 1'b1;
            end
            ST_RDY: begin
                ctl_o.mem_req = 1'b1;
                ctl_o.adr     = ADR_SRC2;
            end
            ST_ADD: begin
                ctl_o.op     = ALU_ADD;
                ctl_o.ld_sum = 1'b1;
            end
            ST_STORE: begin
                ctl_o.mem_req = 1'b1;
                ctl_o.mem_we  = 1'b1;
                ctl_o.adr     = ADR_DEST;
            end
            ST_WB: begin
                ctl_o.rf_we  = 1'b1;
                ctl_o.pc_adv = 1'b1;
                ctl_o.done   = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: a false compare jumps straight to the register write.
    a_r5_skip_on_false: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMP && zero_i) |=> (state_q == ST_WB));
    // R4: a true compare continues with the second source read.
    a_r4_continue_on_true: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMP && !zero_i) |=> (state_q == ST_RDY));
    // R10: no new instruction is taken while one is running.
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_RDREG));
endmodule

// File: rtl/atomic_cmpadd_seq.sv
// Top of the atomic compare-and-add sequencer: holds the instruction,
// PC and datapath registers, and joins the sequencer, register index
// selection and ALU. Assumes a combinational-read register file and a
// single-port memory with one cycle of read latency.
module atomic_cmpadd_seq
    import cmpadd_pkg::*;
#(
    parameter int DW     = 32,
    parameter int RIW    = 5,
    parameter int RS_LSB = 21,
    parameter int RT_LSB = 16,
    parameter int RD_LSB = 11,
    parameter int RU_LSB = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [DW-1:0]  instr,
    input  logic [DW-1:0]  pc_in,
    output logic           busy,
    output logic           done,
    output logic [DW-1:0]  pc_out,
    output logic [RIW-1:0] rf_raddr_a,
    output logic [RIW-1:0] rf_raddr_b,
    input  logic [DW-1:0]  rf_rdata_a,
    input  logic [DW-1:0]  rf_rdata_b,
    output logic           rf_we,
    output logic [RIW-1:0] rf_waddr,
    output logic [DW-1:0]  rf_wdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_lock
);
    localparam int          WBYTES   = DW / 8;
    localparam logic [DW-1:0] CONST_OFS = DW'(WBYTES);
    localparam logic [DW-1:0] PC_STEP   = DW'(2 * WBYTES);

    ctl_t          ctl;
    logic [DW-1:0] ir_q, pc_q;
    logic [DW-1:0] src1_q, src2_q, dst_q;
    logic [DW-1:0] x_q, k_q, sum_q;
    logic          c_q;
    logic [DW-1:0] alu_a, alu_b, alu_res;
    logic          alu_zero;

    cmpadd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .zero_i  (alu_zero),
        .ctl_o   (ctl)
    );

    cmpadd_regsel #(
        .IW(DW), .RIW(RIW), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB),
        .RD_LSB(RD_LSB), .RU_LSB(RU_LSB)
    ) u_regsel (
        .instr_i   (ir_q),
        .pair_hi_i (ctl.pair_hi),
        .raddr_a_o (rf_raddr_a),
        .raddr_b_o (rf_raddr_b),
        .waddr_o   (rf_waddr)
    );

    cmpadd_alu #(.DW(DW)) u_alu (
        .op_i   (ctl.op),
        .a_i    (alu_a),
        .b_i    (alu_b),
        .res_o  (alu_res),
        .zero_o (alu_zero)
    );

    // ALU operand routing: compare first word with incoming constant,
    // or add incoming second word to the held constant.
    always_comb begin
        if (ctl.op == ALU_ADD) begin
            alu_a = mem_rdata;
            alu_b = k_q;
        end else begin
            alu_a = x_q;
            alu_b = mem_rdata;
        end
    end

    // Instruction and PC capture, PC advance at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            pc_q <= '0;
        end else if (ctl.ld_ir) begin
            ir_q <= instr;
            pc_q <= pc_in;
        end else if (ctl.pc_adv) begin
            pc_q <= pc_q + PC_STEP;
        end
    end

    // Register-file operand capture (first pair, then reused port B).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src1_q <= '0;
            src2_q <= '0;
            dst_q  <= '0;
        end else begin
            if (ctl.ld_ab) begin
                src1_q <= rf_rdata_a;
                src2_q <= rf_rdata_b;
            end
            if (ctl.ld_cmp) dst_q <= rf_rdata_b;
        end
    end

    // Memory data, constant, compare flag and sum registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            k_q   <= '0;
            sum_q <= '0;
            c_q   <= 1'b0;
        end else begin
            if (ctl.ld_x)   x_q   <= mem_rdata;
            if (ctl.ld_cmp) begin
                k_q <= mem_rdata;
                c_q <= !alu_zero;
            end
            if (ctl.ld_sum) sum_q <= alu_res;
        end
    end

    // Memory address source selection.
    always_comb begin
        unique case (ctl.adr)
            ADR_SRC1:  mem_addr = src1_q;
            ADR_CONST: mem_addr = pc_q + CONST_OFS;
            ADR_SRC2:  mem_addr = src2_q;
            ADR_DEST:  mem_addr = dst_q;
            default:   mem_addr = src1_q;
        endcase
    end

    // Port outputs.
    assign mem_req   = ctl.mem_req;
    assign mem_we    = ctl.mem_we;
    assign mem_wdata = sum_q;
    assign mem_lock  = ctl.lock;
    assign rf_we     = ctl.rf_we;
    assign rf_wdata  = {{(DW-1){1'b0}}, c_q};
    assign busy      = ctl.busy;
    assign done      = ctl.done;
    assign pc_out    = pc_q;

    // R7: every access happens under the lock.
    a_r7_access_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);
    // R7: lock released the cycle after the register write.
    a_r7_release_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !mem_lock);
    // R6: only the low bit of the written value may be set.
    a_r6_flag_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_wdata[DW-1:1] == '0));
    // R8: completion advances the PC by two words.
    a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (pc_out == $past(pc_out) + PC_STEP));
    // R5: a store only ever follows a true compare.
    a_r5_store_only_true: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> c_q);
endmodule

// File: tb/atomic_cmpadd_seq_bench.sv
module atomic_cmpadd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0, pc_in = '0;
    logic        busy, done, rf_we, mem_req, mem_we, mem_lock;
    logic [31:0] pc_out, rf_rdata_a, rf_rdata_b, rf_wdata;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr;

    always #2.5 clk = ~clk;   // 200 MHz

    atomic_cmpadd_seq u_atomic_cmpadd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
        .busy(busy), .done(done), .pc_out(pc_out),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock)
    );

    // Models: combinational register file, 64-word memory, 1-cycle read.
    logic [31:0] rf [32];
    logic [31:0] mem [64];
    logic [31:0] rdata_q = '0;
    assign rf_rdata_a = rf[rf_raddr_a];
    assign rf_rdata_b = rf[rf_raddr_b];
    assign mem_rdata  = rdata_q;

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req && mem_we)  mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_req && !mem_we) rdata_q <= mem[mem_addr[7:2]];
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard: kind 0 read, 1 write, 2 register write.
    typedef struct packed { logic [1:0] kind; logic [31:0] addr; logic [31:0] data; } exp_t;
    exp_t q[$];

    // Monitor: pops expected activity and compares; also watches the lock.
    logic prev_rfwe = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req || rf_we) begin
                exp_t e;
                exp_t a;
                a.kind = rf_we ? 2'd2 : (mem_we ? 2'd1 : 2'd0);
                a.addr = rf_we ? {27'd0, rf_waddr} : mem_addr;
                a.data = rf_we ? rf_wdata : (mem_we ? mem_wdata : 32'd0);
                if (q.size() == 0) begin
                    check("R3 R5 unexpected access", {30'd0, a.kind}, 32'hFFFF_FFFF);
                end else begin
                    e = q.pop_front();
                    check("R3 access kind", {30'd0, a.kind}, {30'd0, e.kind});
                    check("R3 R2 R11 access address", a.addr, e.addr);
                    check("R4 R6 access data", a.data, e.data);
                end
            end
            if (mem_req) check("R7 access locked", {31'd0, mem_lock}, 32'd1);
            if (prev_rfwe) check("R7 lock released", {31'd0, mem_lock}, 32'd0);
            prev_rfwe <= rf_we;
        end
    end

    function automatic logic [31:0] mk(int rs, int rt, int rd, int ru);
        return {6'h2A, 5'(rs), 5'(rt), 5'(rd), 5'(ru), 6'h15};
    endfunction

    // Driver: pushes the expected activity for one instruction, then runs it.
    task automatic run(int rs, int rt, int rd, int ru, logic [31:0] pc, bit inject);
        logic [31:0] x, k, y, ruv, ru_before;
        bit eq;
        int cnt = 0;
        x = mem[rf[rs][7:2]];
        k = mem[pc[7:2] + 1];
        y = mem[rf[rt][7:2]];
        ruv = rf[ru];
        ru_before = mem[ruv[7:2]];
        eq = (x == k);
        q.push_back('{2'd0, rf[rs], 32'd0});
        q.push_back('{2'd0, pc + 32'd4, 32'd0});
        if (eq) begin
            q.push_back('{2'd0, rf[rt], 32'd0});
            q.push_back('{2'd1, ruv, y + k});
        end
        q.push_back('{2'd2, 32'(rd), {31'd0, eq}});
        @(negedge clk);
        instr = mk(rs, rt, rd, ru); pc_in = pc; start = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) start = 1'b0;
            if (inject && cnt == 2) begin       // R10: start while busy
                start = 1'b1; instr = mk(5, 6, 7, 8); pc_in = 32'h0;
            end
            if (inject && cnt == 3) start = 1'b0;
        end while (!done && cnt < 50);
        check("R9 done latency", 32'(cnt), eq ? 32'd8 : 32'd5);
        @(negedge clk);
        check("R8 pc advance", pc_out, pc + 32'd8);
        check("R10 idle after one instruction", {31'd0, busy}, 32'd0);
        check("R6 destination value", rf[rd], {31'd0, eq});
        if (!eq) check("R5 target unchanged", mem[ruv[7:2]], ru_before);
        check("R3 scoreboard drained", 32'(q.size()), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 32'(i * 4);
        for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 lock", {31'd0, mem_lock}, 32'd0);
        check("R1 req", {31'd0, mem_req}, 32'd0);
        check("R1 rf_we", {31'd0, rf_we}, 32'd0);
        check("R1 pc", pc_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", {31'd0, done}, 32'd0);

        // Match: x at reg1 (0x04 -> word1), constant at 0x84.
        mem[1] = 32'h0000_1234; mem[33] = 32'h0000_1234; mem[2] = 32'h10;
        run(1, 2, 9, 3, 32'h80, 0);
        check("R4 stored sum", mem[3], 32'h1244);

        // Mismatch.
        mem[36] = 32'h5555;
        run(1, 2, 10, 4, 32'h8C, 0);

        // Wrapping match, constant all ones.
        mem[11] = 32'hFFFF_FFFF; mem[41] = 32'hFFFF_FFFF; mem[12] = 32'd2;
        run(11, 12, 13, 14, 32'hA0, 0);
        check("R4 wrap sum", mem[14], 32'd1);

        // Aliased store (third address register equals second source), with start injected.
        mem[21] = 32'h77; mem[45] = 32'h77; mem[22] = 32'h100;
        run(21, 22, 15, 22, 32'hB0, 1);
        check("R4 R11 aliased store", mem[22], 32'h177);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule